// File: doc/BRIEF.md
# Coin-Operated Release Controller

This block tracks the money put into a single coin slot that takes nickels and dimes. Once the credit reaches fifteen cents it raises a release signal that drives the item chute. It gives no change. The credit and the release signal stay where they are until a synchronous reset clears them for the next customer. Each coin arrives as a one-clock pulse on its own input. If a nickel and a dime ever pulse together, the dime is counted and the nickel is dropped.

A build-time switch picks how the release signal is made:
- **Decoded:** release is decoded from the credit register.
- **Registered:** release is the output of a dedicated flip-flop. That flip-flop loads the full-credit condition of the next state, so no logic sits between a register and the pin. It rises on the same edge as the credit register.

Credit is held in units of five cents in a two-bit register. The codes are 00 for nothing, 01 for five cents, 10 for ten cents and 11 for fifteen cents.

Top module: `coin_release_ctrl`

## Requirements
- R1: A clock edge that samples `rst` high sets the credit to 0 and `open_o` low, whatever the coin inputs are. After that edge, exactly three nickels are needed before `open_o` rises.
- R2: A nickel pulse with no dime adds one unit (five cents) to the credit at the next clock edge.
- R3: A dime pulse adds two units (ten cents) at the next edge. From ten cents, a dime moves the credit to fifteen cents and the excess is dropped.
- R4: In a cycle with neither coin input high, the credit keeps its value.
- R5: `open_o` is high exactly when the credit is fifteen cents (code 11). That state is kept, whatever coins arrive, until reset.
- R6: When `nickel_i` and `dime_i` are high in the same cycle, only the dime is counted.
- R7: With `OPEN_REGISTERED` = 1, `open_o` comes from its own flip-flop. It rises on the clock edge on which the credit becomes fifteen cents, with no extra cycle of delay.
- R8: With `OPEN_REGISTERED` = 0, `open_o` is decoded from the credit register and has the same cycle timing as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nickel_i | input | 1 | One-cycle pulse per five-cent coin |
| dime_i | input | 1 | One-cycle pulse per ten-cent coin |
| open_o | output | 1 | Release chute; high while credit is fifteen cents |

## Verification
Every result is due one clock edge after the cycle that carries its stimulus. A coin or reset driven in one cycle changes the credit, and `open_o` in both variants, on the next rising edge. The bench drives inputs on the falling edge and samples `open_o` 2 ns after the following rising edge, so it always observes the state settled by exactly one edge. Credit cannot be seen directly, so the bench works it out from the release timing. Both variants run side by side on the same stimulus, and the bench checks each of them against one arithmetic model on every cycle.

// File: rtl/coin_pkg.sv
package coin_pkg;

  // Saturating credit sum, all values in units of five cents.
  function automatic int unsigned credit_add(input int unsigned cur,
                                             input int unsigned add,
                                             input int unsigned full);
    int unsigned sum;
    sum = cur + add;
    return (sum > full) ? full : sum;
  endfunction

  // Units a cycle's coin inputs are worth; the dime wins a collision.
  function automatic int unsigned coin_units(input logic nickel,
                                             input logic dime,
                                             input int unsigned nickel_units,
                                             input int unsigned dime_units);
    if (dime)   return dime_units;
    if (nickel) return nickel_units;
    return 0;
  endfunction

endpackage

// File: rtl/coin_sel.sv
module coin_sel (
  input  logic nickel_i,
  input  logic dime_i,
  output logic nickel_eff,
  output logic dime_eff
);
  // Dime takes priority when both pulses collide.
  always_comb begin
    dime_eff   = dime_i;
    nickel_eff = nickel_i & ~dime_i;
  end
endmodule

// File: rtl/credit_step.sv
module credit_step #(
  parameter int unsigned CREDIT_W     = 2,
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned FULL_UNITS   = 3
) (
  input  logic [CREDIT_W-1:0] credit_q,
  input  logic                nickel_eff,
  input  logic                dime_eff,
  output logic [CREDIT_W-1:0] credit_d
);
  int unsigned add_units;

  always_comb begin
    add_units = coin_pkg::coin_units(nickel_eff, dime_eff, NICKEL_UNITS, DIME_UNITS);
    credit_d  = CREDIT_W'(coin_pkg::credit_add(32'(credit_q), add_units, FULL_UNITS));
  end
endmodule

// File: rtl/credit_store.sv
module credit_store #(
  parameter int unsigned CREDIT_W        = 2,
  parameter int unsigned FULL_UNITS      = 3,
  parameter bit          OPEN_REGISTERED = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CREDIT_W-1:0] credit_d,
  output logic [CREDIT_W-1:0] credit_q,
  output logic                open_o
);
  localparam logic [CREDIT_W-1:0] FULL_CODE = CREDIT_W'(FULL_UNITS);

  always_ff @(posedge clk) begin
    if (rst) credit_q <= '0;
    else     credit_q <= credit_d;
  end

  if (OPEN_REGISTERED) begin : g_reg
    logic open_q;
    // Precomputed full condition of the next state, loaded in parallel.
    always_ff @(posedge clk) begin
      if (rst) open_q <= 1'b0;
      else     open_q <= (credit_d == FULL_CODE);
    end
    assign open_o = open_q;

    // R7: separate flop stays aligned with the credit register
    assert_open_aligned_R7: assert property (@(posedge clk) disable iff (rst)
      open_o == (credit_q == FULL_CODE));
  end else begin : g_moore
    assign open_o = (credit_q == FULL_CODE);
  end

  // R5: full credit is kept until reset
  assert_full_kept_R5: assert property (@(posedge clk) disable iff (rst)
    (credit_q == FULL_CODE) |=> (credit_q == FULL_CODE) && open_o);
endmodule

// File: rtl/coin_release_ctrl.sv
module coin_release_ctrl #(
  parameter int unsigned CREDIT_W        = 2,
  parameter int unsigned NICKEL_UNITS    = 1,
  parameter int unsigned DIME_UNITS      = 2,
  parameter int unsigned FULL_UNITS      = 3,
  parameter bit          OPEN_REGISTERED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  logic                nickel_eff;
  logic                dime_eff;
  logic [CREDIT_W-1:0] credit_q;
  logic [CREDIT_W-1:0] credit_d;

  coin_sel u_sel (
    .nickel_i   (nickel_i),
    .dime_i     (dime_i),
    .nickel_eff (nickel_eff),
    .dime_eff   (dime_eff)
  );

  credit_step #(
    .CREDIT_W     (CREDIT_W),
    .NICKEL_UNITS (NICKEL_UNITS),
    .DIME_UNITS   (DIME_UNITS),
    .FULL_UNITS   (FULL_UNITS)
  ) u_step (
    .credit_q   (credit_q),
    .nickel_eff (nickel_eff),
    .dime_eff   (dime_eff),
    .credit_d   (credit_d)
  );

  credit_store #(
    .CREDIT_W        (CREDIT_W),
    .FULL_UNITS      (FULL_UNITS),
    .OPEN_REGISTERED (OPEN_REGISTERED)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .credit_d (credit_d),
    .credit_q (credit_q),
    .open_o   (open_o)
  );

  // R1: leaving reset, credit is empty and chute closed
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (credit_q == '0) && !open_o);

  // R2: a lone nickel adds one unit
  assert_nickel_step_R2: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && !dime_i) |=>
      (32'(credit_q) == coin_pkg::credit_add(32'($past(credit_q)), NICKEL_UNITS, FULL_UNITS)));

  // R3: a lone dime adds two units, saturating
  assert_dime_step_R3: assert property (@(posedge clk) disable iff (rst)
    (dime_i && !nickel_i) |=>
      (32'(credit_q) == coin_pkg::credit_add(32'($past(credit_q)), DIME_UNITS, FULL_UNITS)));

  // R4: idle cycles hold the credit
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(credit_q));

  // R6: colliding coins count as a dime only
  assert_dime_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i) |=>
      (32'(credit_q) == coin_pkg::credit_add(32'($past(credit_q)), DIME_UNITS, FULL_UNITS)));
endmodule

// File: tb/test_coin_release_ctrl.sv
module test_coin_release_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_i = 1'b0;
  logic dime_i = 1'b0;
  logic open_reg;
  logic open_moore;
  int   total = 0;
  int   bad = 0;
  int   exp_cents = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;

  coin_release_ctrl #(.OPEN_REGISTERED(1'b1)) i_coin_release_ctrl (
    .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i), .open_o(open_reg));

  coin_release_ctrl #(.OPEN_REGISTERED(1'b0)) i_coin_release_ctrl_moore (
    .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i), .open_o(open_moore));

  task automatic check_open(input string req);
    logic want;
    want = (exp_cents >= 15);
    total++;
    if (open_reg !== want) begin
      bad++;
      $display("FAIL %s/R7 registered open actual=%b expected=%b cents=%0d", req, open_reg, want, exp_cents);
    end
    total++;
    if (open_moore !== want) begin
      bad++;
      $display("FAIL %s/R8 decoded open actual=%b expected=%b cents=%0d", req, open_moore, want, exp_cents);
    end
  endtask

  // One cycle: drive at falling edge, sample 2 ns after the next rising edge.
  task automatic step(input logic r, input logic n, input logic d);
    string req;
    @(negedge clk);
    rst = r; nickel_i = n; dime_i = d;
    @(posedge clk);
    if (r) begin
      exp_cents = 0; req = "R1";
    end else begin
      if (exp_cents >= 15)  req = "R5";
      else if (n && d)      req = "R6";
      else if (d)           req = "R3";
      else if (n)           req = "R2";
      else                  req = "R4";
      if (d)      exp_cents = exp_cents + 10;
      else if (n) exp_cents = exp_cents + 5;
      if (exp_cents > 15) exp_cents = 15;
    end
    #2;
    check_open(req);
  endtask

  initial begin
    logic [7:0] lfsr;
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);           // R1 reset state
    // R1: reset wins over a coin in the same cycle
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    // Exhaustive: every credit level against every coin combination
    for (int start = 0; start < 4; start++) begin
      for (int combo = 0; combo < 4; combo++) begin
        step(1'b1, 1'b0, 1'b0);
        for (int k = 0; k < start; k++) step(1'b0, 1'b1, 1'b0);
        step(1'b0, combo[0], combo[1]);
        step(1'b0, 1'b0, 1'b0);        // R4 idle hold
        step(1'b0, 1'b0, 1'b0);
        // top up with nickels to expose the reached credit via open timing
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b0);
      end
    end
    // Pseudo-random mix with occasional resets
    lfsr = 8'hA5;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[7:4] == 4'hF, lfsr[0], lfsr[1] & lfsr[2]);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule